// File: doc/BRIEF.md
# Translation Buffer Maintenance Registers

This block holds the three control registers through which software edits a set-associative translation buffer: an access register (frame number and permission flags), a control register (way select, read and write enables, address-space identifier) and an entry-address register (virtual page number). A single CPU write port selects one register per cycle. The block also owns the tag/data array that these registers read and write. Lookups against the array belong to other logic.

A write to the access register while the write-enable bit is set stores one entry. The target slot is set by the current way field and the low bits of the page number. After the store, the way field steps to the next way. A control-register write with the read bit set copies the addressed entry back into all three read-back registers. The block keeps each register's last written value apart from its read-back value. Commits therefore use what software wrote, even after a read has overwritten the visible copy. An entry's internal valid flag is set only for page numbers below the top quarter of the page-number space.

When software changes the identifier in the control register, the block raises a one-cycle flush pulse that carries the previous identifier. Other logic uses this pulse to drop cached translations.

Top module: `tlbm_ctrl_regs`

## Requirements
- R1: After reset all three read-back registers read zero, the flush pulse is low, and every entry holds zero.
- R2: An access-register write (wr_sel 0) stores nothing when control-register bit 18 (write enable) is clear. A later read of every slot returns zero data and zero identifier.
- R3: When control bit 18 is set, an access-register write stores one entry. The slot index is way × SETS + (page mod SETS). The way comes from the low bits of the control read-back field [23:20]. The page comes from bits [21:2] of the last entry-address write. The identifier comes from bits [11:4] of the last control write, even after a read has replaced the visible identifier.
- R4: A stored entry keeps only the frame number [19:0] and flags [24:21] of the written access value. The global flag, bit 20, is kept in the tag. Bits [31:25] are dropped.
- R5: After each stored entry the control way field [23:20] becomes (way + 1) mod WAYS. Writes that store nothing leave it unchanged.
- R6: An access-register write never changes the access read-back value.
- R7: An entry-address write (wr_sel 2) updates every read-back bit except the page field [21:2], which keeps its old value.
- R8: A control write (wr_sel 1) with bit 19 set loads the access read-back with the entry data, with bit 20 set from the entry's global flag and bits [31:25] kept. It loads the control read-back with the written value, its [11:4] field replaced by the entry identifier. It loads the entry-address page field [21:2] with the entry page.
- R9: A control write whose [11:4] differs from the previous control write raises flush_pulse for exactly the next cycle, with flush_pid equal to the previous identifier. An equal identifier raises no pulse.
- R10: A control write with bit 19 clear makes the control read-back equal to the written value.
- R11: The read in R8 picks its slot from the way field of the value being written and the page from the last entry-address write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 access, 1 control, 2 entry address |
| wr_value | input | 32 | Write data |
| acc_q | output | 32 | Access register read-back |
| misc_q | output | 32 | Control register read-back |
| pte_q | output | 32 | Entry-address register read-back |
| flush_pulse | output | 1 | One-cycle identifier-change flush request |
| flush_pid | output | PID_W | Identifier to flush, valid with flush_pulse |

## Verification
A wrong slot index or a corrupted tag field stays hidden until a later read-bit control write targets that slot. It then shows on all three read-back registers in the cycle after that write. A stale write shadow shows only through a later commit followed by a read, so the sweep mixes reads between commits. Way-counter and flush errors show at the ports one cycle after the write that caused them.

// File: rtl/tlbm_pkg.sv
// Package: field positions and masks shared by the maintenance register block.
// Assumes 32-bit registers with a 20-bit page number and a 20-bit frame number.
package tlbm_pkg;
    localparam int REG_W   = 32;
    localparam int VPN_W   = 20;
    localparam int PFN_W   = 20;
    localparam int VPN_LSB = 2;
    localparam int PID_LSB = 4;
    localparam int WE_BIT  = 18;
    localparam int RD_BIT  = 19;
    localparam int WAY_LSB = 20;
    localparam int WAY_FW  = 4;
    localparam int G_BIT   = 20;
    localparam int X_BIT   = 21;
    localparam int C_BIT   = 24;

    localparam logic [REG_W-1:0] PFN_MASK  = (REG_W'(1) << PFN_W) - REG_W'(1);
    localparam logic [REG_W-1:0] PERM_MASK = REG_W'(4'hF) << X_BIT;
    localparam logic [REG_W-1:0] KEEP_MASK = PFN_MASK | PERM_MASK;
    localparam logic [REG_W-1:0] IGN_MASK  = ~((REG_W'(1) << (C_BIT + 1)) - REG_W'(1));
    localparam logic [REG_W-1:0] VPN_MASK  = ((REG_W'(1) << VPN_W) - REG_W'(1)) << VPN_LSB;
    localparam logic [VPN_W-1:0] VALID_LIMIT = VPN_W'(3) << (VPN_W - 2);

    typedef enum logic [1:0] {
        SEL_ACC  = 2'd0,
        SEL_MISC = 2'd1,
        SEL_PTE  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/tlbm_entry_store.sv
// Module: tag/data storage for all ways and sets, one write port, one
// combinational read port. Assumes at most one write per cycle.
module tlbm_entry_store #(
    parameter int ENTRIES = 16,
    parameter int TAG_W   = 30,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data
);
    logic [TAG_W-1:0]  tag_q  [ENTRIES];
    logic [DATA_W-1:0] data_q [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        // Per-slot register: cleared on reset, loaded when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q[e]  <= '0;
                data_q[e] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                tag_q[e]  <= wr_tag;
                data_q[e] <= wr_data;
            end
        end
    end

    // Read port: combinational select of the addressed slot.
    assign rd_tag  = tag_q[rd_idx];
    assign rd_data = data_q[rd_idx];

    // R3
    store_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tag_q[$past(wr_idx)] == $past(wr_tag)) &&
                  (data_q[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/tlbm_commit_fmt.sv
// Module: builds the tag and data words for an entry commit from the written
// access value, the shadow page number and the shadow identifier.
module tlbm_commit_fmt
    import tlbm_pkg::*;
#(
    parameter int PID_W = 8,
    localparam int TAG_W = VPN_W + 2 + PID_W
) (
    input  logic [REG_W-1:0] acc_value,
    input  logic [VPN_W-1:0] vpn,
    input  logic [PID_W-1:0] pid,
    output logic [TAG_W-1:0] tag,
    output logic [REG_W-1:0] data
);
    logic valid;

    // Tag assembly: page, global flag, valid flag, identifier.
    always_comb begin
        valid = (vpn < VALID_LIMIT);
        tag   = {vpn, acc_value[G_BIT], valid, pid};
        data  = acc_value & KEEP_MASK;
    end
endmodule

// File: rtl/tlbm_pid_watch.sv
// Module: compares each control write's identifier with the previous one and
// emits a registered one-cycle flush request carrying the old identifier.
module tlbm_pid_watch #(
    parameter int PID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  logic [PID_W-1:0] new_pid,
    input  logic [PID_W-1:0] old_pid,
    output logic             flush_pulse,
    output logic [PID_W-1:0] flush_pid
);
    // Flush request register: set for one cycle on an identifier change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_pulse <= 1'b0;
            flush_pid   <= '0;
        end else begin
            flush_pulse <= stb && (new_pid != old_pid);
            if (stb && (new_pid != old_pid))
                flush_pid <= old_pid;
        end
    end

    // R9
    flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_pulse) |-> $past(stb) && ($past(new_pid) != $past(old_pid)));
endmodule

// File: rtl/tlbm_ctrl_regs.sv
// Module: the three maintenance registers, their write shadows, entry commit,
// entry read-back and way auto-increment. Assumes WAYS and SETS are powers of
// two, at least 2, and WAYS fits the 4-bit way field.
module tlbm_ctrl_regs
    import tlbm_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int SETS  = 4,
    parameter int PID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [REG_W-1:0] wr_value,
    output logic [REG_W-1:0] acc_q,
    output logic [REG_W-1:0] misc_q,
    output logic [REG_W-1:0] pte_q,
    output logic             flush_pulse,
    output logic [PID_W-1:0] flush_pid
);
    localparam int WAY_W   = $clog2(WAYS);
    localparam int SET_W   = $clog2(SETS);
    localparam int ENTRIES = WAYS * SETS;
    localparam int IDX_W   = WAY_W + SET_W;
    localparam int TAG_W   = VPN_W + 2 + PID_W;

    reg_sel_e         sel;
    logic             acc_write, misc_write, pte_write, commit, rd_load;
    logic [VPN_W-1:0] sh_vpn;
    logic [PID_W-1:0] sh_pid;
    logic [WAY_W-1:0] cur_way, way_inc, rd_way;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic [TAG_W-1:0] new_tag, rd_tag;
    logic [REG_W-1:0] new_data, rd_data, misc_loaded;
    logic [VPN_W-1:0] ent_vpn;
    logic             ent_g, ent_valid;
    logic [PID_W-1:0] ent_pid;

    // Write decode and slot index formation.
    always_comb begin
        sel        = reg_sel_e'(wr_sel);
        acc_write  = wr_en && (sel == SEL_ACC);
        misc_write = wr_en && (sel == SEL_MISC);
        pte_write  = wr_en && (sel == SEL_PTE);
        commit     = acc_write && misc_q[WE_BIT];
        rd_load    = misc_write && wr_value[RD_BIT];
        cur_way    = misc_q[WAY_LSB +: WAY_W];
        way_inc    = cur_way + WAY_W'(1);
        rd_way     = wr_value[WAY_LSB +: WAY_W];
        wr_idx     = {cur_way, sh_vpn[SET_W-1:0]};
        rd_idx     = {rd_way, sh_vpn[SET_W-1:0]};
    end

    // Field split of the entry being read.
    always_comb begin
        ent_vpn   = rd_tag[TAG_W-1 -: VPN_W];
        ent_g     = rd_tag[PID_W + 1];
        ent_valid = rd_tag[PID_W];
        ent_pid   = rd_tag[PID_W-1:0];
        misc_loaded = wr_value;
        misc_loaded[PID_LSB +: PID_W] = ent_pid;
    end

    tlbm_commit_fmt #(.PID_W(PID_W)) u_fmt (
        .acc_value (wr_value),
        .vpn       (sh_vpn),
        .pid       (sh_pid),
        .tag       (new_tag),
        .data      (new_data)
    );

    tlbm_entry_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .DATA_W(REG_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit),
        .wr_idx  (wr_idx),
        .wr_tag  (new_tag),
        .wr_data (new_data),
        .rd_idx  (rd_idx),
        .rd_tag  (rd_tag),
        .rd_data (rd_data)
    );

    tlbm_pid_watch #(.PID_W(PID_W)) u_pid (
        .clk         (clk),
        .rst_n       (rst_n),
        .stb         (misc_write),
        .new_pid     (wr_value[PID_LSB +: PID_W]),
        .old_pid     (sh_pid),
        .flush_pulse (flush_pulse),
        .flush_pid   (flush_pid)
    );

    // Write shadows: last written page number and identifier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_vpn <= '0;
            sh_pid <= '0;
        end else begin
            if (pte_write)
                sh_vpn <= wr_value[VPN_LSB +: VPN_W];
            if (misc_write)
                sh_pid <= wr_value[PID_LSB +: PID_W];
        end
    end

    // Access read-back: changes only on an entry read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (rd_load)
            acc_q <= (acc_q & IGN_MASK) | rd_data | (REG_W'(ent_g) << G_BIT);
    end

    // Control read-back: written value, entry identifier on read, way step on commit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            misc_q <= '0;
        else if (misc_write)
            misc_q <= wr_value[RD_BIT] ? misc_loaded : wr_value;
        else if (commit)
            misc_q[WAY_LSB +: WAY_FW] <= WAY_FW'(way_inc);
    end

    // Entry-address read-back: page field held on writes, loaded on entry read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pte_q <= '0;
        else if (pte_write)
            pte_q <= (wr_value & ~VPN_MASK) | (pte_q & VPN_MASK);
        else if (rd_load)
            pte_q[VPN_LSB +: VPN_W] <= ent_vpn;
    end

    // R5
    way_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> misc_q[WAY_LSB +: WAY_FW] == WAY_FW'((int'($past(cur_way)) + 1) % WAYS));
    // R6
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_write |=> acc_q == $past(acc_q));
    // R7
    pte_vpn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pte_write |=> pte_q[VPN_LSB +: VPN_W] == $past(pte_q[VPN_LSB +: VPN_W]));
    // R10
    misc_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (misc_write && !wr_value[RD_BIT]) |=> misc_q == $past(wr_value));
    // R3
    entry_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_load && rd_tag != '0) |-> ent_valid == (ent_vpn < VALID_LIMIT));
endmodule

// File: tb/tb_tlbm_ctrl_regs.sv
module tb_tlbm_ctrl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_value = '0;
    logic [31:0] acc_q, misc_q, pte_q;
    logic        flush_pulse;
    logic [7:0]  flush_pid;

    int checks = 0;
    int errors = 0;

    // Bench model state (4 ways x 4 sets, 8-bit identifier).
    logic [31:0] m_data [16];
    logic [19:0] m_vpn  [16];
    logic        m_g    [16];
    logic [7:0]  m_pid  [16];
    logic [31:0] m_acc = '0, m_misc = '0, m_pte = '0;
    logic [19:0] m_sh_vpn = '0;
    logic [7:0]  m_sh_pid = '0;
    logic        exp_flush;
    logic [7:0]  exp_fpid;

    always #10 clk = ~clk;

    tlbm_ctrl_regs #(.WAYS(4), .SETS(4), .PID_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_value(wr_value),
        .acc_q(acc_q), .misc_q(misc_q), .pte_q(pte_q),
        .flush_pulse(flush_pulse), .flush_pid(flush_pid)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Apply one write to the model, drive it, and compare all outputs.
    task automatic wr(input string req, input logic [1:0] sel, input logic [31:0] v);
        int idx;
        logic [1:0] way;
        exp_flush = 1'b0;
        case (sel)
            2'd0: if (m_misc[18]) begin
                way = m_misc[21:20];
                idx = int'(way) * 4 + int'(m_sh_vpn[1:0]);
                m_vpn[idx]  = m_sh_vpn;
                m_g[idx]    = v[20];
                m_pid[idx]  = m_sh_pid;
                m_data[idx] = v & 32'h01EF_FFFF;
                m_misc[23:20] = 4'((int'(way) + 1) % 4);
            end
            2'd1: begin
                if (v[11:4] != m_sh_pid) begin
                    exp_flush = 1'b1;
                    exp_fpid  = m_sh_pid;
                end
                if (v[19]) begin
                    idx = int'(v[21:20]) * 4 + int'(m_sh_vpn[1:0]);
                    m_acc = (m_acc & 32'hFE00_0000) | m_data[idx] | (32'(m_g[idx]) << 20);
                    m_misc = v;
                    m_misc[11:4] = m_pid[idx];
                    m_pte[21:2] = m_vpn[idx];
                end else begin
                    m_misc = v;
                end
                m_sh_pid = v[11:4];
            end
            default: begin
                m_pte = (v & ~32'h003F_FFFC) | (m_pte & 32'h003F_FFFC);
                m_sh_vpn = v[21:2];
            end
        endcase
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_value = v;
        @(negedge clk);
        wr_en = 1'b0;
        chk(req, "acc_q", acc_q, m_acc);
        chk(req, "misc_q", misc_q, m_misc);
        chk(req, "pte_q", pte_q, m_pte);
        chk("R9", "flush_pulse", 32'(flush_pulse), 32'(exp_flush));
        if (exp_flush) begin
            chk("R9", "flush_pid", 32'(flush_pid), 32'(exp_fpid));
            @(negedge clk);
            chk("R9", "flush_pulse one cycle", 32'(flush_pulse), 32'd0);
        end
    endtask

    // Read every slot through read-bit control writes.
    task automatic read_all(input string req, input logic [7:0] pid_base);
        for (int w = 0; w < 4; w++) begin
            for (int s = 0; s < 4; s++) begin
                wr(req, 2'd2, 32'hA5C0_0003 ^ (32'(s) << 2) ^ (32'(w) << 9));
                wr(req, 2'd1, 32'h5A00_000B | (32'd1 << 19) | (32'(w) << 20) |
                              (32'(pid_base + 8'(w * 4 + s)) << 4));
            end
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_data[i] = '0; m_vpn[i] = '0; m_g[i] = 1'b0; m_pid[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "acc_q reset", acc_q, 32'd0);
        chk("R1", "misc_q reset", misc_q, 32'd0);
        chk("R1", "pte_q reset", pte_q, 32'd0);
        chk("R1", "flush reset", 32'(flush_pulse), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "acc_q after reset", acc_q, 32'd0);

        // R2: write enable clear, access writes store nothing (and R6 hold)
        wr("R10", 2'd1, 32'h0000_0000);
        for (int k = 0; k < 4; k++)
            wr("R2", 2'd0, 32'hFFFF_FFFF ^ 32'(k));
        read_all("R2", 8'h00);

        // R3 R4 R5: exhaustive commit sweep over sets and ways
        for (int s = 0; s < 4; s++) begin
            wr("R7", 2'd2, 32'h0000_0000 | (((32'(s) * 32'h3_1001) + (s == 3 ? 32'hC_0000 : 0)) << 2) | 32'h8000_0001);
            wr("R10", 2'd1, (32'd1 << 18) | (32'(8'h30 + 8'(s)) << 4) | 32'h0000_0005);
            for (int w = 0; w < 4; w++)
                wr("R5", 2'd0, (32'h1234_5678 * 32'(s * 4 + w + 1)) ^ 32'hFE10_0000);
        end
        // way counter wrapped back to 0 after four commits per set
        chk("R5", "way field wrap", 32'(misc_q[23:20]), 32'd0);
        read_all("R8", 8'h40);
        read_all("R11", 8'h40);

        // R3: commit after a read uses the written identifier, not the loaded one
        wr("R7", 2'd2, 32'h0000_0004);
        wr("R8", 2'd1, (32'd1 << 19) | (32'd1 << 18) | (32'd2 << 20) | (32'h77 << 4));
        wr("R3", 2'd0, 32'h01FF_F00D);
        wr("R3", 2'd1, (32'd1 << 19) | (32'd2 << 20) | (32'h77 << 4));
        chk("R3", "pid from write shadow", 32'(misc_q[11:4]), 32'h77);
        // R9: same identifier, no flush
        wr("R9", 2'd1, (32'h77 << 4) | 32'h0000_0001);
        // R6: access write with enable clear leaves everything
        wr("R6", 2'd0, 32'hDEAD_BEEF);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule